// File: doc/BRIEF.md
# Prioritised Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from local-bus peripherals into one interrupt line for the processor. Each request line is captured in a source register every clock. The source register is ANDed with an enable mask that software controls, and any bit that survives both raises the combined interrupt output.

Software uses a small 16-bit register port. One offset returns a ready-made vector for the highest-priority pending request, where the lowest-numbered line has the highest priority. Another offset reads and writes the enable mask. An interrupt is cleared only when the requesting peripheral drops its line. There is no acknowledge register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each source bit takes the level that its request input had at the previous rising clock edge, so an input change reaches the source register one edge later.
- R2: A line is pending when its source bit and its mask bit are both 1. A line that is masked off has no effect on the output or on the vector.
- R3: `cpuIrq` is a registered signal. At each rising edge it takes 1 if any line was pending during the preceding cycle, and 0 otherwise.
- R4: A read at byte offset 0x000 returns a vector. If i is the lowest-numbered pending line, the vector is (i+1)*4 (line 0 gives 4, line 4 gives 20, line 15 gives 64). If nothing is pending, the vector is 0.
- R5: A write at byte offset 0x002 loads bit k of `regWrData` into the enable bit of line k at the next edge. A read at offset 0x002 returns the mask. `cpuIrq` reflects the new mask one edge after the write lands.
- R6: A write at any offset other than 0x002 changes no state. Read data is combinational from the current register contents.
- R7: A read at any offset other than 0x000 and 0x002 returns 0.
- R8: While reset is asserted, the mask is 0x0010, the source register is 0 and `cpuIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Level-sensitive request lines, bit k is line k |
| regAddr | input | 12 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| cpuIrq | output | 1 | Combined interrupt to the processor |

## Verification
The assertions assume that the request lines and the register port change only between clock edges. They also assume that one write strobe means one write. They assume nothing about which lines may be high together, so any mix of request levels and mask values is legal. The stimulus drives every input on the falling edge and holds it steady through the following rising edge. It pulses `regWrEn` for one cycle at a time and selects offsets from the two defined registers and from random undefined addresses, so that the ignore paths are exercised as well.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Geometry of the controller
  parameter int NUM_SRC = 16;
  parameter int REG_W   = 16;
  parameter int ADDR_W  = 12;

  // Byte offsets decoded by the register port (software depends on these)
  parameter logic [ADDR_W-1:0] OFS_VECTOR = 12'h000;
  parameter logic [ADDR_W-1:0] OFS_MASK   = 12'h002;

  // Enable mask value after reset
  parameter logic [NUM_SRC-1:0] MASK_RST = 16'h0010;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic maskWr;     // load the enable mask this edge
    logic selVector;  // drive the priority vector onto read data
    logic selMask;    // drive the mask onto read data
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W = irq_prio_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] VEC_OFS  = irq_prio_pkg::OFS_VECTOR,
  parameter logic [ADDR_W-1:0] MASK_OFS = irq_prio_pkg::OFS_MASK
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobes_t      strb
);

  logic hitVector;
  logic hitMask;

  // Full decode: aliasing would let stray writes reach the mask
  assign hitVector = (regAddr == VEC_OFS);
  assign hitMask   = (regAddr == MASK_OFS);

  always_comb begin
    strb           = '0;
    strb.maskWr    = regWrEn & hitMask;
    strb.selVector = hitVector;
    strb.selMask   = hitMask;
  end

endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
  parameter int REG_W   = irq_prio_pkg::REG_W,
  parameter logic [NUM_SRC-1:0] MASK_INIT = irq_prio_pkg::MASK_RST
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               cpuIrq,
  output logic [NUM_SRC-1:0] srcBits,
  output logic [NUM_SRC-1:0] maskBits
);

  localparam int IDX_W = $clog2(NUM_SRC + 1);
  localparam int VEC_W = IDX_W + 2;

  logic [NUM_SRC-1:0] pending;
  logic [IDX_W-1:0]   winIdx;
  logic [VEC_W-1:0]   vector;

  // One capture flop per request line
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) srcBits[g] <= 1'b0;
      else       srcBits[g] <= irqIn[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskBits <= MASK_INIT;
    else if (strb.maskWr) maskBits <= regWrData[NUM_SRC-1:0];
  end

  assign pending = srcBits & maskBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= 1'b0;
    else       cpuIrq <= |pending;
  end

  // Lowest index wins: scan downwards so the last hit is the smallest
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) winIdx = IDX_W'(i + 1);
    end
  end

  assign vector = {winIdx, 2'b00};

  always_comb begin
    regRdData = '0;
    if (strb.selVector)    regRdData = REG_W'(vector);
    else if (strb.selMask) regRdData = REG_W'(maskBits);
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
  parameter int REG_W   = irq_prio_pkg::REG_W,
  parameter int ADDR_W  = irq_prio_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               cpuIrq
);

  ctrlStrobes_t       strb;
  logic [NUM_SRC-1:0] srcBits;
  logic [NUM_SRC-1:0] maskBits;

  irq_prio_decode #(
    .ADDR_W   (ADDR_W),
    .VEC_OFS  (ADDR_W'(OFS_VECTOR)),
    .MASK_OFS (ADDR_W'(OFS_MASK))
  ) u_decode (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  irq_prio_datapath #(
    .NUM_SRC   (NUM_SRC),
    .REG_W     (REG_W),
    .MASK_INIT (NUM_SRC'(MASK_RST))
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .irqIn     (irqIn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cpuIrq    (cpuIrq),
    .srcBits   (srcBits),
    .maskBits  (maskBits)
  );

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
  parameter int REG_W   = irq_prio_pkg::REG_W,
  parameter int ADDR_W  = irq_prio_pkg::ADDR_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [REG_W-1:0]   regWrData,
  input logic [REG_W-1:0]   regRdData,
  input logic               cpuIrq,
  input logic [NUM_SRC-1:0] srcBits,
  input logic [NUM_SRC-1:0] maskBits
);

  assert_src_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (srcBits == $past(irqIn)));

  assert_irq_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cpuIrq == |($past(srcBits) & $past(maskBits))));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_MASK)) |=> (maskBits == $past(regWrData[NUM_SRC-1:0])));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(OFS_MASK)) |=> $stable(maskBits));

  assert_vector_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_VECTOR) && (srcBits & maskBits) == '0) |-> (regRdData == '0));

  assert_vector_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_VECTOR)) |-> (regRdData[1:0] == 2'b00 && regRdData <= REG_W'(4 * NUM_SRC)));

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((srcBits & maskBits) == '0) |=> !cpuIrq);

  assert_undef_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != ADDR_W'(OFS_VECTOR) && regAddr != ADDR_W'(OFS_MASK)) |-> (regRdData == '0));

endmodule

bind irq_prio_ctrl irq_prio_checker #(
  .NUM_SRC (NUM_SRC),
  .REG_W   (REG_W),
  .ADDR_W  (ADDR_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .cpuIrq    (cpuIrq),
  .srcBits   (srcBits),
  .maskBits  (maskBits)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cpuIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] maskM;
  logic [15:0] srcM;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cpuIrq(cpuIrq)
  );

  function automatic logic [15:0] expVector(logic [15:0] s, logic [15:0] m);
    logic [15:0] p = s & m;
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
    return 16'h0;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic readAt(logic [11:0] a, output logic [15:0] d);
    regAddr = a;
    #0.3;
    d = regRdData;
  endtask

  // One step: drive at falling edge, land on the rising edge, verify reads,
  // then one more edge for the registered interrupt output.
  task automatic step(logic [15:0] lines, bit wr, logic [11:0] a, logic [15:0] data);
    logic [15:0] d;
    logic [11:0] junk;
    irqIn = lines; regWrEn = wr; regAddr = a; regWrData = data;
    @(posedge clk);
    srcM = lines;
    if (wr && a == 12'h002) maskM = data;
    @(negedge clk);
    regWrEn = 1'b0;
    readAt(12'h000, d); check("R4 vector", d, expVector(srcM, maskM));
    readAt(12'h002, d); check("R5 mask readback", d, maskM);
    junk = 12'($urandom_range(4, 4095));
    readAt(junk, d); check("R7 undefined read", d, 16'h0);
    @(posedge clk);
    @(negedge clk);
    check("R3 cpuIrq", {15'h0, cpuIrq}, {15'h0, |(srcM & maskM)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    void'($urandom(32'h1F3A));
    maskM = 16'h0010; srcM = '0;
    irqIn = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R8: reset state even with all lines high
    check("R8 cpuIrq in reset", {15'h0, cpuIrq}, 16'h0);
    readAt(12'h002, d); check("R8 mask reset", d, 16'h0010);
    readAt(12'h000, d); check("R8 source cleared", d, 16'h0);
    irqIn = '0;
    @(negedge clk); rstN = 1'b1;

    // R1/R2: all lines with reset mask -> only line 4 counts
    step(16'hFFFF, 0, 12'h000, 16'h0);
    check("R2 reset mask selects line 4", expVector(srcM, maskM), 16'd20);
    // R2: masked lines only
    step(16'h00EF, 0, 12'h000, 16'h0);
    // R5: open whole mask, highest line alone -> 64
    step(16'h8000, 1, 12'h002, 16'hFFFF);
    readAt(12'h000, d); check("R4 line 15 vector", d, 16'd64);
    // R4: line 0 beats everything
    step(16'hFFFF, 0, 12'h000, 16'h0);
    readAt(12'h000, d); check("R4 line 0 vector", d, 16'd4);
    // R6: writes to vector offset and undefined offset ignored
    step(16'h0000, 1, 12'h000, 16'h1234);
    readAt(12'h002, d); check("R6 write at 0x000 ignored", d, 16'hFFFF);
    step(16'h0000, 1, 12'h004, 16'h0000);
    readAt(12'h002, d); check("R6 write at 0x004 ignored", d, 16'hFFFF);
    // R5: mask closed with lines active drops the output
    step(16'hFFFF, 1, 12'h002, 16'h0000);
    check("R5 closed mask quiet", {15'h0, cpuIrq}, 16'h0);
    // R1: source follows a falling line
    step(16'h0000, 1, 12'h002, 16'h0100);
    step(16'h0100, 0, 12'h000, 16'h0);
    readAt(12'h000, d); check("R1 line 8 captured", d, 16'd36);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int pick = $urandom_range(0, 3);
      a = (pick < 2) ? 12'h002 : (pick == 2) ? 12'h000 : 12'($urandom_range(1, 4095));
      step(16'($urandom), bit'($urandom_range(0, 1)), a, 16'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule